// File: doc/BRIEF.md
# Serial Control Register Loader with Frame-Synchronous Update

This block receives configuration bytes over a two-wire serial link: a clock line and a data line driven by a host controller. Both lines, and a vertical sync input, pass through two-flop synchronisers into the system clock domain. Rising edges of the serial clock are detected there. Every frame carries an 8-bit address and then an 8-bit value, each sent least significant bit first. When the address selects one of three control slots, the value is kept in a shadow buffer for that slot.

The shadow buffers do not drive the outputs directly. A high level on the vertical sync input cancels any frame that is only partly received. When the sync level drops again, the block copies all three shadow buffers into the active registers in the same cycle. A picture processing path can therefore change its geometry and filter settings only between fields. The active registers are the block's outputs. A flat bus carries all of them, and two named field ports expose the compression code and the chroma coring selection.

Top module: `ser_ctrl_loader`

## Requirements
- R1: A synchronous active-high reset sets the active registers to zero and empties the shadow buffers, so a sync pulse after reset loads zeros.
- R2: On each rising serial clock edge the block takes one bit from the data line. The first bit of a byte is its bit 0. Data line changes and falling clock edges capture nothing.
- R3: A completed frame changes only a shadow buffer. The outputs keep their value until the next sync release.
- R4: Addresses 0xF0, 0xF1 and 0xF2 select slots 0, 1 and 2, and slot k appears on `ctrl_regs_o[8k+7:8k]`. A value that follows any other address is received in full and then discarded.
- R5: The bit after a value byte is taken as bit 0 of a new address, so frames may follow each other with no gap.
- R6: While the synchronised sync input is high, any partial address or value is dropped. The next frame starts from bit 0 of an address.
- R7: All active registers take the shadow contents together on the third rising system clock edge that samples the sync pin low after a high period. The first two such edges leave the outputs unchanged.
- R8: Serial clock edges that arrive while sync is high, including a whole frame, change no shadow buffer.
- R9: When the final value bit's clock edge and the rise of sync reach the block in the same cycle, the sync wins and the value is not stored.
- R10: `compress_o` equals slot 0 bits 7:0, and `coring_o` equals slot 1 bits 1:0.
- R11: A later write to a slot replaces an earlier one. Writing one slot leaves the others unchanged. Shadow contents persist across sync pulses that have no new writes in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock line, asynchronous |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| vsync_i | input | 1 | Vertical sync level: high aborts a frame, the falling edge loads the active registers |
| ctrl_regs_o | output | 24 | Active registers, slot k at bits 8k+7:8k |
| compress_o | output | 8 | Compression code (slot 0) |
| coring_o | output | 2 | Chroma coring selection (slot 1, bits 1:0) |

## Verification
Two events can reach the receiver in the same system cycle: the serial clock edge that completes a value byte, which writes a shadow buffer, and the rise of the sync input, which aborts the frame. The bench provokes this by driving the last serial clock rise and the sync rise on the same falling clock edge. Both lines go through identical synchronisers, so the two events arrive together. The coincidence is judged after the sync release by checking that the target slot still holds its earlier value. A second case drives a whole frame while sync is high and checks that the release loads the unchanged shadows.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;

    // Receiver states; the all-zero encoding is the post-reset state.
    typedef enum logic [1:0] {
        RX_INIT = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2,
        RX_HOLD = 2'd3
    } rx_state_e;

endpackage

// File: rtl/ser_ctrl_sync.sv
module ser_ctrl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.pipe[STAGES-1];

endmodule

// File: rtl/ser_ctrl_framer.sv
module ser_ctrl_framer
    import ser_ctrl_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_REGS  = 3,
    parameter int BASE_ADDR = 240,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              vsync_s,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              load_en
);

    localparam int                CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] BASE_V = BYTE_W'(BASE_ADDR);
    localparam logic [BYTE_W-1:0] NUM_V  = BYTE_W'(NUM_REGS);

    typedef struct packed {
        rx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shift;
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic               sclk_prev;
    } framer_t;

    framer_t f_d, f_q;

    logic              rise;
    logic              last_bit;
    logic [BYTE_W-1:0] word;
    logic [BYTE_W-1:0] offset;

    always_comb begin
        rise     = sclk_s & ~f_q.sclk_prev;
        last_bit = (f_q.cnt == LAST);
        // new bit enters at the top, so the first bit ends up at bit 0
        word     = {sdata_s, f_q.shift[BYTE_W-1:1]};
        offset   = word - BASE_V;

        f_d           = f_q;
        f_d.sclk_prev = sclk_s;
        wr_en         = 1'b0;
        load_en       = 1'b0;

        if (vsync_s) begin
            f_d.state = RX_HOLD;
            f_d.cnt   = '0;
            f_d.hit   = 1'b0;
        end else begin
            unique case (f_q.state)
                RX_HOLD: begin
                    load_en   = 1'b1;
                    f_d.state = RX_INIT;
                end
                RX_INIT, RX_ADDR: begin
                    if (rise) begin
                        f_d.shift = word;
                        if (last_bit) begin
                            f_d.cnt   = '0;
                            f_d.state = RX_DATA;
                            f_d.hit   = (offset < NUM_V);
                            f_d.idx   = offset[IDX_W-1:0];
                        end else begin
                            f_d.cnt   = f_q.cnt + CNT_W'(1);
                            f_d.state = RX_ADDR;
                        end
                    end
                end
                RX_DATA: begin
                    if (rise) begin
                        f_d.shift = word;
                        if (last_bit) begin
                            wr_en     = f_q.hit;
                            f_d.cnt   = '0;
                            f_d.hit   = 1'b0;
                            f_d.state = RX_ADDR;
                        end else begin
                            f_d.cnt   = f_q.cnt + CNT_W'(1);
                        end
                    end
                end
                default: f_d.state = RX_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_idx  = f_q.idx;
    assign wr_data = word;

    // R6: a high sync level leaves the receiver idle with an empty count
    p_abort_clears_r6: assert property (@(posedge clk) disable iff (rst)
        vsync_s |=> (f_q.state == RX_HOLD && f_q.cnt == '0));

    // R7: a falling sync level is only ever seen from the hold state
    p_release_from_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_s) |-> (f_q.state == RX_HOLD));

    // R5: a stored value returns the receiver to address bit 0
    p_frame_wraps_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (f_q.state == RX_ADDR && f_q.cnt == '0));

    // R4: writes only reach existing slots
    p_write_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_REGS));

    // R8: no write is issued while the sync level holds the receiver
    p_hold_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (f_q.state == RX_HOLD) |-> !wr_en);

endmodule

// File: rtl/ser_ctrl_bank.sv
module ser_ctrl_bank #(
    parameter int BYTE_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       load_en,
    output logic [NUM_REGS*BYTE_W-1:0] active_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] shadow;
        logic [NUM_REGS-1:0][BYTE_W-1:0] active;
    } bank_t;

    bank_t b_d, b_q;

    logic [NUM_REGS-1:0] sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                b_d.shadow[i] = wr_data;
            end
        end
        if (load_en) begin
            b_d.active = b_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign active_o = b_q.active;

    // R3: outputs move only on a load strobe
    p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(b_q.active));

    // R7: a load copies every slot of the shadow bank at once
    p_active_copy_r7: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (b_q.active == $past(b_q.shadow)));

    // R11: at most one slot is written per cycle
    p_one_slot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R11: shadows persist when no write is issued
    p_shadow_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(b_q.shadow));

endmodule

// File: rtl/ser_ctrl_loader.sv
module ser_ctrl_loader #(
    parameter int BYTE_W      = 8,
    parameter int NUM_REGS    = 3,
    parameter int BASE_ADDR   = 240,
    parameter int SYNC_STAGES = 2,
    parameter int CORE_W      = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    input  logic                       vsync_i,
    output logic [NUM_REGS*BYTE_W-1:0] ctrl_regs_o,
    output logic [BYTE_W-1:0]          compress_o,
    output logic [CORE_W-1:0]          coring_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [2:0]        sync_out;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              load_en;

    ser_ctrl_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({vsync_i, ser_dat_i, ser_clk_i}),
        .dout (sync_out)
    );

    ser_ctrl_framer #(
        .BYTE_W    (BYTE_W),
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR),
        .IDX_W     (IDX_W)
    ) framer_i (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_out[0]),
        .sdata_s (sync_out[1]),
        .vsync_s (sync_out[2]),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .load_en (load_en)
    );

    ser_ctrl_bank #(
        .BYTE_W   (BYTE_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .load_en  (load_en),
        .active_o (ctrl_regs_o)
    );

    assign compress_o = ctrl_regs_o[BYTE_W-1:0];
    assign coring_o   = ctrl_regs_o[BYTE_W +: CORE_W];

endmodule

// File: tb/ser_ctrl_loader_tb_top.sv
module ser_ctrl_loader_tb_top;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        sclk = 1'b0;
    logic        sdat = 1'b0;
    logic        vs   = 1'b0;
    logic [23:0] regs;
    logic [7:0]  cmp;
    logic [1:0]  cor;

    always #10 clk = ~clk;

    ser_ctrl_loader dut_i (
        .clk         (clk),
        .rst         (rst),
        .ser_clk_i   (sclk),
        .ser_dat_i   (sdat),
        .vsync_i     (vs),
        .ctrl_regs_o (regs),
        .compress_o  (cmp),
        .coring_o    (cor)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit started = 0;
    bit done    = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // history of pin values seen at past rising edges: [0]=1 edge ago ...
    int h_c[3], h_d[3], h_v[3];
    int m_mode;              // 0 idle after release, 1 receiving, 2 held by sync
    int m_cnt, m_addr, m_val;
    int m_sh[3], m_act[3];
    int c_cur, c_prev, d_cur, v_cur;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                h_c[i] = 0; h_d[i] = 0; h_v[i] = 0;
                m_sh[i] = 0; m_act[i] = 0;
            end
            m_mode = 0; m_cnt = 0; m_addr = 0; m_val = 0;
        end else begin
            c_cur = h_c[1]; c_prev = h_c[2]; d_cur = h_d[1]; v_cur = h_v[1];
            if (v_cur != 0) begin
                m_mode = 2; m_cnt = 0; m_addr = 0; m_val = 0;
            end else if (m_mode == 2) begin
                for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
                m_mode = 0;
            end else if (c_cur != 0 && c_prev == 0) begin
                if (m_cnt < 8) m_addr = m_addr | (d_cur << m_cnt);
                else           m_val  = m_val  | (d_cur << (m_cnt - 8));
                m_cnt++;
                m_mode = 1;
                if (m_cnt == 16) begin
                    if (m_addr >= 'hF0 && m_addr <= 'hF2) m_sh[m_addr - 'hF0] = m_val;
                    m_cnt = 0; m_addr = 0; m_val = 0;
                end
            end
            h_c[2] = h_c[1]; h_c[1] = h_c[0]; h_c[0] = int'(sclk);
            h_d[2] = h_d[1]; h_d[1] = h_d[0]; h_d[0] = int'(sdat);
            h_v[2] = h_v[1]; h_v[1] = h_v[0]; h_v[0] = int'(vs);
        end
        started = 1;
    end

    // per-cycle comparison against the model (R7 timing, R10 field ports)
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_w;
            exp_w = (m_act[2] << 16) | (m_act[1] << 8) | m_act[0];
            check(regs == 24'(exp_w), "R7 cycle model regs", int'(regs), exp_w);
            check(cmp == 8'(m_act[0]) && cor == 2'(m_act[1] & 3),
                  "R10 cycle model fields", int'({cor, cmp}), ((m_act[1] & 3) << 8) | m_act[0]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_bit(input bit b);
        @(negedge clk); sdat = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        sdat = ~b;   // R2: data flips on the falling edge and must not be captured
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] v);
        send_byte(a);
        send_byte(v);
    endtask

    task automatic vsync_pulse();
        @(negedge clk); vs = 1'b1;
        repeat (6) @(negedge clk);
        vs = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_regs(input logic [23:0] e, input string tag);
        @(negedge clk);
        check(regs == e, tag, int'(regs), int'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_regs(24'h000000, "R1 reset value");

        // R2 R3: three frames reach shadows only
        send_frame(8'hF0, 8'hA5);
        send_frame(8'hF1, 8'h03);
        send_frame(8'hF2, 8'h5C);
        expect_regs(24'h000000, "R3 outputs unchanged before sync");
        vsync_pulse();
        expect_regs(24'h5C03A5, "R2 LSB-first frames loaded");
        check(cmp == 8'hA5, "R10 compression field", int'(cmp), 'hA5);
        check(cor == 2'd3, "R10 coring field", int'(cor), 3);

        // R7: exact load cycle
        send_frame(8'hF0, 8'h11);
        @(negedge clk); vs = 1'b1;
        repeat (6) @(negedge clk);
        vs = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(regs == 24'h5C03A5, "R7 no load on second edge", int'(regs), 'h5C03A5);
        @(negedge clk);
        check(regs == 24'h5C0311, "R7 load on third edge", int'(regs), 'h5C0311);
        repeat (4) @(negedge clk);

        // R4: unrecognised addresses
        send_frame(8'hF3, 8'hFF);
        send_frame(8'h70, 8'hFF);
        send_frame(8'hEF, 8'hFF);
        vsync_pulse();
        expect_regs(24'h5C0311, "R4 unmatched values discarded");

        // R6: partial address aborted
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        vsync_pulse();
        send_frame(8'hF1, 8'h2A);
        vsync_pulse();
        expect_regs(24'h5C2A11, "R6 frame after aborted address");
        // R6: partial value aborted
        send_byte(8'hF2);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        vsync_pulse();
        send_frame(8'hF0, 8'h77);
        vsync_pulse();
        expect_regs(24'h5C2A77, "R6 aborted value not stored");

        // R8: whole frame while sync high
        @(negedge clk); vs = 1'b1;
        send_frame(8'hF2, 8'hEE);
        @(negedge clk); vs = 1'b0;
        repeat (6) @(negedge clk);
        expect_regs(24'h5C2A77, "R8 frame under sync ignored");
        vsync_pulse();
        expect_regs(24'h5C2A77, "R8 shadows untouched under sync");

        // R9: last value bit and sync rise together
        send_byte(8'hF2);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        @(negedge clk); sdat = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b1; vs = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        vs = 1'b0;
        repeat (6) @(negedge clk);
        expect_regs(24'h5C2A77, "R9 sync wins over final bit");

        // R5 R11: back-to-back frames, overwrite, neighbours kept
        send_frame(8'hF2, 8'h99);
        send_frame(8'hF0, 8'h01);
        send_frame(8'hF0, 8'h02);
        send_frame(8'hF1, 8'hC6);
        vsync_pulse();
        expect_regs(24'h99C602, "R5 back-to-back frames and R11 last write wins");
        check(cor == 2'd2, "R10 coring field after update", int'(cor), 2);
        vsync_pulse();
        expect_regs(24'h99C602, "R11 shadows persist across sync");

        // R1: reset clears shadows too
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_regs(24'h000000, "R1 reset clears active");
        vsync_pulse();
        expect_regs(24'h000000, "R1 reset clears shadows");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-run actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule